// File: doc/BRIEF.md
# Asynchronous Static Memory Access Sequencer

This block carries out one asynchronous read or write on an external NOR flash, SRAM or PSRAM device for each request it accepts from a simple valid/ready port on the system side. It steps through a fixed order of timed phases. Address setup comes first, then address hold (used only when address and data share one bus), then data setup, then a bus turnaround gap. It then raises a one-cycle completion pulse. Each phase length is counted in system clock cycles and comes from its own runtime timing input.

The device side has active-low chip selects (one per 64 MB bank window), output enable, write enable and address-valid strobes. It also has the in-window address, a shared address/data bus with a separate drive enable, and the bus input that read data returns on. The timing inputs and the bus mode are captured when a request is accepted, so the integrator may change them at any time without corrupting an access in flight.

Top module: `smc_access_seq`

## Requirements
- R1: After reset the block is idle. `req_ready` is 1, `rsp_valid` is 0, every chip select and the `mem_oe_n`, `mem_we_n` and `mem_adv_n` strobes are 1, and `mem_ad_oe` is 0.
- R2: Address setup lasts `cfg_aset` cycles (0 to 15), counted as cycles with a chip select low before any data strobe. A value of 0 skips the phase, so the next phase begins in the first cycle after acceptance.
- R3: When `cfg_muxed` is 1, address hold follows address setup for `cfg_ahld` cycles (1 to 15; a value of 0 gives 1). `mem_adv_n` is low for exactly the address setup and hold cycles. When `cfg_muxed` is 0 there is no hold phase and `mem_adv_n` stays 1.
- R4: Data setup lasts `cfg_dset`+1 cycles (1 to 256). It is the span in which `mem_we_n` (write) or `mem_oe_n` (read) is low. The two are never low together.
- R5: After data setup, every chip select is high for `cfg_turn` cycles (0 to 15). Then `rsp_valid` is 1 for exactly one cycle.
- R6: In a write, `mem_we_n` is low for the whole data setup and `mem_oe_n` stays 1. `mem_ad_oe` is 1 and `mem_ad_o` equals the accepted write data in every data setup cycle.
- R7: In a read, `mem_ad_oe` is 0 throughout data setup and turnaround. `rsp_rdata` holds the value present on `mem_ad_i` in the last data setup cycle.
- R8: During an access exactly one chip select is low, from the first address (or data) cycle through the last data setup cycle. The low select is bit `req_addr[AW-1:WIN_W]` of `mem_cs_n` (WIN_W = 26). `mem_addr` carries `req_addr[WIN_W-1:0]`.
- R9: `req_ready` is 0 from the cycle after acceptance until the completion pulse ends. No request is taken in that span.
- R10: Changes to any `cfg_*` input after acceptance do not change the phase lengths or bus mode of the access in progress.
- R11: When `cfg_muxed` is 1, `mem_ad_oe` is 1 and `mem_ad_o` equals `req_addr[DW-1:0]` in every address setup and hold cycle. When `cfg_muxed` is 0, `mem_ad_oe` is 0 in those cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle, request taken when valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW (28) | Byte address; upper bits pick the bank |
| req_wdata | input | DW (16) | Write data |
| cfg_muxed | input | 1 | Address and data share the bus |
| cfg_aset | input | 4 | Address setup cycles |
| cfg_ahld | input | 4 | Address hold cycles (muxed only) |
| cfg_dset | input | 8 | Data setup cycles minus one |
| cfg_turn | input | 4 | Turnaround cycles |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | DW (16) | Read data |
| mem_cs_n | output | NBANK (4) | Active-low bank selects |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_we_n | output | 1 | Active-low write enable |
| mem_adv_n | output | 1 | Active-low address valid |
| mem_addr | output | WIN_W (26) | Address within the bank window |
| mem_ad_o | output | DW (16) | Bus output value |
| mem_ad_oe | output | 1 | Bus drive enable |
| mem_ad_i | input | DW (16) | Bus input value |

## Verification
Two events can fall on the same clock edge. One is the skipping of empty phases. The other is the assertion of a data strobe or the completion pulse. With a zero address setup in non-muxed mode, the data strobe must appear in the very first cycle after acceptance. With a zero turnaround, the completion pulse must directly follow the last data cycle. The bench runs these zero-length cases alongside one-cycle and 256-cycle data setups. It counts strobe cycles at the ports and compares them with counts predicted from the timing inputs. The bench model changes the bus input value every cycle, so a read sampled one cycle early or late returns the wrong word.

// File: rtl/smc_pkg.sv
package smc_pkg;

   localparam int ASET_W = 4;
   localparam int AHLD_W = 4;
   localparam int DSET_W = 8;
   localparam int TURN_W = 4;
   localparam int CNT_W  = DSET_W;

   typedef enum logic [2:0] {
      PH_IDLE = 3'd0,
      PH_ASET = 3'd1,
      PH_AHLD = 3'd2,
      PH_DSET = 3'd3,
      PH_TURN = 3'd4,
      PH_DONE = 3'd5
   } phase_e;

   typedef struct packed {
      logic              muxed;
      logic [ASET_W-1:0] aset;
      logic [AHLD_W-1:0] ahld;
      logic [DSET_W-1:0] dset;
      logic [TURN_W-1:0] turn;
   } timing_t;

   // Counter preload (length minus one) for a timed phase.
   function automatic logic [CNT_W-1:0] preload(phase_e p, timing_t c);
      logic [CNT_W-1:0] v;
      v = '0;
      case (p)
         PH_ASET: v = CNT_W'(c.aset - ASET_W'(1));
         PH_AHLD: v = (c.ahld == '0) ? '0 : CNT_W'(c.ahld - AHLD_W'(1));
         PH_DSET: v = CNT_W'(c.dset);
         PH_TURN: v = CNT_W'(c.turn - TURN_W'(1));
         default: v = '0;
      endcase
      return v;
   endfunction

endpackage

// File: rtl/smc_cfg_hold.sv
module smc_cfg_hold
   import smc_pkg::*;
(
   input  logic    clk,
   input  logic    rst_n,
   input  logic    capture,
   input  timing_t cfg_d,
   output timing_t cfg_q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       cfg_q <= '0;
      else if (capture) cfg_q <= cfg_d;
   end

endmodule

// File: rtl/smc_phase_timer.sv
module smc_phase_timer #(
   parameter int CW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [CW-1:0] load_val,
   output logic          last
);

   if (CW < 1) begin : g_bad_cw
      $error("smc_phase_timer: CW must be at least 1");
   end

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              cnt_q <= '0;
      else if (load)           cnt_q <= load_val;
      else if (cnt_q != '0)    cnt_q <= cnt_q - CW'(1);
   end

   assign last = (cnt_q == '0);

   // R4: a running phase counts down by one per cycle
   a_r4_count_step: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - CW'(1)));

endmodule

// File: rtl/smc_bus_drive.sv
module smc_bus_drive
   import smc_pkg::*;
#(
   parameter int DW     = 16,
   parameter int NBANK  = 4,
   parameter int BANK_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  phase_e            phase,
   input  logic              muxed,
   input  logic              write,
   input  logic [BANK_W-1:0] bank,
   input  logic [DW-1:0]     addr_lo,
   input  logic [DW-1:0]     wdata,
   output logic [NBANK-1:0]  cs_n,
   output logic              oe_n,
   output logic              we_n,
   output logic              adv_n,
   output logic [DW-1:0]     ad_o,
   output logic              ad_oe
);

   logic addr_ph, data_ph, sel_ph;

   assign addr_ph = (phase == PH_ASET) || (phase == PH_AHLD);
   assign data_ph = (phase == PH_DSET);
   assign sel_ph  = addr_ph || data_ph;

   for (genvar b = 0; b < NBANK; b++) begin : g_cs
      assign cs_n[b] = !(sel_ph && (bank == BANK_W'(b)));
   end

   assign adv_n = !(muxed && addr_ph);
   assign oe_n  = !(data_ph && !write);
   assign we_n  = !(data_ph && write);
   assign ad_oe = (muxed && addr_ph) || (data_ph && write);
   assign ad_o  = addr_ph ? addr_lo : wdata;

   // R8: never more than one bank selected
   a_r8_one_bank: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(~cs_n) <= 1);

   // R4: read and write strobes exclusive
   a_r4_strobe_excl: assert property (@(posedge clk) disable iff (!rst_n)
      !(!oe_n && !we_n));

   // R7: the bus is never driven while the device drives it
   a_r7_no_contention: assert property (@(posedge clk) disable iff (!rst_n)
      !oe_n |-> !ad_oe);

   // R3: address valid never overlaps a data strobe
   a_r3_adv_apart: assert property (@(posedge clk) disable iff (!rst_n)
      !adv_n |-> (oe_n && we_n));

endmodule

// File: rtl/smc_access_seq.sv
module smc_access_seq
   import smc_pkg::*;
#(
   parameter int DW     = 16,
   parameter int NBANK  = 4,
   parameter int WIN_W  = 26,
   localparam int BANK_W = (NBANK > 1) ? $clog2(NBANK) : 1,
   localparam int AW     = WIN_W + BANK_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic              req_write,
   input  logic [AW-1:0]     req_addr,
   input  logic [DW-1:0]     req_wdata,
   input  logic              cfg_muxed,
   input  logic [ASET_W-1:0] cfg_aset,
   input  logic [AHLD_W-1:0] cfg_ahld,
   input  logic [DSET_W-1:0] cfg_dset,
   input  logic [TURN_W-1:0] cfg_turn,
   output logic              rsp_valid,
   output logic [DW-1:0]     rsp_rdata,
   output logic [NBANK-1:0]  mem_cs_n,
   output logic              mem_oe_n,
   output logic              mem_we_n,
   output logic              mem_adv_n,
   output logic [WIN_W-1:0]  mem_addr,
   output logic [DW-1:0]     mem_ad_o,
   output logic              mem_ad_oe,
   input  logic [DW-1:0]     mem_ad_i
);

   if (NBANK < 2 || (NBANK & (NBANK - 1)) != 0) begin : g_bad_nbank
      $error("smc_access_seq: NBANK must be a power of two, at least 2");
   end
   if (DW < 8 || DW % 8 != 0) begin : g_bad_dw
      $error("smc_access_seq: DW must be a multiple of 8");
   end
   if (DW > WIN_W) begin : g_bad_win
      $error("smc_access_seq: DW must not exceed WIN_W");
   end

   phase_e           phase_q, phase_d;
   timing_t          cfg_in, cfg_q, cfg_eff;
   logic             accept, step, load, last;
   logic [CNT_W-1:0] load_val;
   logic             wr_q;
   logic [AW-1:0]    addr_q;
   logic [DW-1:0]    wdata_q, rdata_q;

   assign cfg_in = '{muxed: cfg_muxed, aset: cfg_aset, ahld: cfg_ahld,
                     dset: cfg_dset, turn: cfg_turn};
   assign accept  = req_valid && (phase_q == PH_IDLE);
   assign cfg_eff = accept ? cfg_in : cfg_q;

   smc_cfg_hold u_cfg (
      .clk     (clk),
      .rst_n   (rst_n),
      .capture (accept),
      .cfg_d   (cfg_in),
      .cfg_q   (cfg_q)
   );

   always_comb begin
      phase_d = phase_q;
      step    = 1'b0;
      case (phase_q)
         PH_IDLE: if (accept) begin
            step = 1'b1;
            if (cfg_in.aset != '0)  phase_d = PH_ASET;
            else if (cfg_in.muxed)  phase_d = PH_AHLD;
            else                    phase_d = PH_DSET;
         end
         PH_ASET: if (last) begin
            step    = 1'b1;
            phase_d = cfg_q.muxed ? PH_AHLD : PH_DSET;
         end
         PH_AHLD: if (last) begin
            step    = 1'b1;
            phase_d = PH_DSET;
         end
         PH_DSET: if (last) begin
            step    = 1'b1;
            phase_d = (cfg_q.turn != '0) ? PH_TURN : PH_DONE;
         end
         PH_TURN: if (last) begin
            step    = 1'b1;
            phase_d = PH_DONE;
         end
         PH_DONE: begin
            step    = 1'b1;
            phase_d = PH_IDLE;
         end
         default: phase_d = PH_IDLE;
      endcase
   end

   assign load     = step && (phase_d inside {PH_ASET, PH_AHLD, PH_DSET, PH_TURN});
   assign load_val = preload(phase_d, cfg_eff);

   smc_phase_timer #(.CW(CNT_W)) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (load),
      .load_val (load_val),
      .last     (last)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= PH_IDLE;
         wr_q    <= 1'b0;
         addr_q  <= '0;
         wdata_q <= '0;
         rdata_q <= '0;
      end else begin
         phase_q <= phase_d;
         if (accept) begin
            wr_q    <= req_write;
            addr_q  <= req_addr;
            wdata_q <= req_wdata;
         end
         if (phase_q == PH_DSET && last && !wr_q) rdata_q <= mem_ad_i;
      end
   end

   smc_bus_drive #(.DW(DW), .NBANK(NBANK), .BANK_W(BANK_W)) u_drive (
      .clk     (clk),
      .rst_n   (rst_n),
      .phase   (phase_q),
      .muxed   (cfg_q.muxed),
      .write   (wr_q),
      .bank    (addr_q[AW-1:WIN_W]),
      .addr_lo (addr_q[DW-1:0]),
      .wdata   (wdata_q),
      .cs_n    (mem_cs_n),
      .oe_n    (mem_oe_n),
      .we_n    (mem_we_n),
      .adv_n   (mem_adv_n),
      .ad_o    (mem_ad_o),
      .ad_oe   (mem_ad_oe)
   );

   assign mem_addr  = addr_q[WIN_W-1:0];
   assign req_ready = (phase_q == PH_IDLE);
   assign rsp_valid = (phase_q == PH_DONE);
   assign rsp_rdata = rdata_q;

   // R9: once a request is taken the port is busy
   a_r9_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> !req_ready);

   // R5: completion is a single-cycle pulse
   a_r5_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |=> !rsp_valid);

   // R5: selects are released before completion
   a_r5_done_released: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> (&mem_cs_n));

endmodule

// File: tb/smc_access_seq_test.sv
`timescale 1ns/1ps
module smc_access_seq_test;

   localparam int DW = 16;
   localparam int NBANK = 4;
   localparam int WIN_W = 26;
   localparam int AW = 28;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic req_valid = 1'b0;
   logic req_ready;
   logic req_write = 1'b0;
   logic [AW-1:0] req_addr = '0;
   logic [DW-1:0] req_wdata = '0;
   logic cfg_muxed = 1'b0;
   logic [3:0] cfg_aset = '0, cfg_ahld = '0, cfg_turn = '0;
   logic [7:0] cfg_dset = '0;
   logic rsp_valid;
   logic [DW-1:0] rsp_rdata;
   logic [NBANK-1:0] mem_cs_n;
   logic mem_oe_n, mem_we_n, mem_adv_n, mem_ad_oe;
   logic [WIN_W-1:0] mem_addr;
   logic [DW-1:0] mem_ad_o;
   logic [DW-1:0] mem_ad_i = 16'h5a00;

   always #2.5 clk = ~clk;

   smc_access_seq uut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
      .cfg_muxed(cfg_muxed), .cfg_aset(cfg_aset), .cfg_ahld(cfg_ahld),
      .cfg_dset(cfg_dset), .cfg_turn(cfg_turn), .rsp_valid(rsp_valid),
      .rsp_rdata(rsp_rdata), .mem_cs_n(mem_cs_n), .mem_oe_n(mem_oe_n),
      .mem_we_n(mem_we_n), .mem_adv_n(mem_adv_n), .mem_addr(mem_addr),
      .mem_ad_o(mem_ad_o), .mem_ad_oe(mem_ad_oe), .mem_ad_i(mem_ad_i)
   );

   // Device model: bus value changes every cycle
   always @(posedge clk) mem_ad_i <= mem_ad_i + 16'h0137;

   int n_checks = 0;
   int n_fail = 0;
   int cycles = 0;
   bit done_flag = 0;

   task automatic check(bit ok, string req, string what, longint act, longint exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   typedef struct {
      bit wr; int bank; int pre; int adv; int dlen; int turn;
      logic [DW-1:0] wdata; logic [DW-1:0] alo; logic [WIN_W-1:0] win;
      bit mux;
   } exp_t;
   exp_t q[$];
   bit busy = 0;

   // Driver: push expectation, offer request, optionally disturb config
   task automatic access(bit wr, logic [AW-1:0] a, logic [DW-1:0] wd, bit mux,
                         int as, int ah, int ds, int tu, bit scramble);
      exp_t e;
      @(negedge clk);
      while (!req_ready) @(negedge clk);
      e.wr = wr; e.bank = int'(a[AW-1:WIN_W]); e.mux = mux;
      e.pre = as + (mux ? ((ah == 0) ? 1 : ah) : 0);
      e.adv = mux ? e.pre : 0;
      e.dlen = ds + 1; e.turn = tu;
      e.wdata = wd; e.alo = a[DW-1:0]; e.win = a[WIN_W-1:0];
      q.push_back(e);
      req_write = wr; req_addr = a; req_wdata = wd;
      cfg_muxed = mux; cfg_aset = 4'(as); cfg_ahld = 4'(ah);
      cfg_dset = 8'(ds); cfg_turn = 4'(tu);
      req_valid = 1'b1;
      @(posedge clk);
      busy = 1;
      @(negedge clk);
      req_valid = 1'b0;
      req_addr = ~a; req_wdata = ~wd;
      if (scramble) begin   // R10: disturb timing mid-access
         cfg_muxed = ~mux; cfg_aset = 4'(as) ^ 4'hf; cfg_ahld = 4'(ah) ^ 4'h7;
         cfg_dset = 8'(ds) ^ 8'h3c; cfg_turn = 4'(tu) ^ 4'h9;
      end
   endtask

   // Monitor: measure phase lengths at the ports, compare on completion
   int pre_c = 0, adv_c = 0, dat_c = 0, turn_c = 0;
   bit seen_data = 0;
   logic [DW-1:0] last_mem = '0;
   bit prev_rsp = 0;

   always @(negedge clk) begin
      if (rst_n) begin
         bit dat, sel;
         dat = !mem_we_n || !mem_oe_n;
         sel = !(&mem_cs_n);
         if (prev_rsp) check(!rsp_valid, "R5", "completion pulse width", rsp_valid, 0);
         if (busy) check(!req_ready, "R9", "ready while busy", req_ready, 0);
         if (q.size() > 0) begin
            exp_t e;
            e = q[0];
            if (sel) begin
               check(~mem_cs_n == NBANK'(1 << e.bank), "R8", "bank select", ~mem_cs_n, 1 << e.bank);
               check(mem_addr == e.win, "R8", "window address", mem_addr, e.win);
            end
            if (sel && !dat && !seen_data) begin
               pre_c++;
               if (!mem_adv_n) adv_c++;
               check(mem_ad_oe == e.mux, "R11", "address phase drive", mem_ad_oe, e.mux);
               if (e.mux) check(mem_ad_o == e.alo, "R11", "address on bus", mem_ad_o, e.alo);
            end
            if (dat) begin
               seen_data = 1;
               dat_c++;
               check(mem_adv_n, "R3", "adv during data", mem_adv_n, 1);
               if (e.wr) begin
                  check(!mem_we_n && mem_oe_n, "R6", "write strobes", {mem_we_n, mem_oe_n}, 2'b01);
                  check(mem_ad_oe && mem_ad_o == e.wdata, "R6", "write data", mem_ad_o, e.wdata);
               end else begin
                  check(!mem_oe_n && mem_we_n, "R7", "read strobes", {mem_we_n, mem_oe_n}, 2'b10);
                  check(!mem_ad_oe, "R7", "bus drive in read", mem_ad_oe, 0);
                  last_mem = mem_ad_i;
               end
            end
            if (!sel && seen_data && !rsp_valid) begin
               turn_c++;
               check(!mem_ad_oe && mem_we_n && mem_oe_n, "R5", "turnaround idle bus", mem_ad_oe, 0);
            end
            if (rsp_valid) begin
               check(pre_c == e.pre, "R2", "address phase cycles", pre_c, e.pre);
               check(adv_c == e.adv, "R3", "address valid cycles", adv_c, e.adv);
               check(dat_c == e.dlen, "R4", "data setup cycles", dat_c, e.dlen);
               check(turn_c == e.turn, "R5", "turnaround cycles", turn_c, e.turn);
               if (!e.wr) check(rsp_rdata == last_mem, "R7", "read data", rsp_rdata, last_mem);
               void'(q.pop_front());
               pre_c = 0; adv_c = 0; dat_c = 0; turn_c = 0; seen_data = 0;
               busy = 0;
            end
         end else if (rsp_valid) begin
            check(0, "R9", "unexpected completion", 1, 0);
         end
         prev_rsp = rsp_valid;
      end
   end

   // Watchdog
   always @(posedge clk) begin
      cycles++;
      if (cycles > 50000 && !done_flag) begin
         n_checks++; n_fail++;
         $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state
      check(req_ready, "R1", "ready", req_ready, 1);
      check(!rsp_valid, "R1", "rsp_valid", rsp_valid, 0);
      check(&mem_cs_n, "R1", "chip selects", mem_cs_n, 4'hf);
      check(mem_oe_n && mem_we_n && mem_adv_n, "R1", "strobes",
            {mem_oe_n, mem_we_n, mem_adv_n}, 3'b111);
      check(!mem_ad_oe, "R1", "bus drive", mem_ad_oe, 0);

      // R2 R4 R5: all-minimum non-muxed read (zero setup, one data cycle, no gap)
      access(0, 28'h0001234, 16'h0, 0, 0, 0, 0, 0, 0);
      // R6: non-muxed write, all maxima, bank 3
      access(1, 28'hC00BEEF, 16'hA55A, 0, 15, 5, 255, 15, 0);
      // R3 R11: muxed read, hold 0 treated as 1, zero setup
      access(0, 28'h4002468, 16'h0, 1, 0, 0, 3, 1, 0);
      // R3 R6 R11: muxed write with long hold
      access(1, 28'h8013579, 16'h1234, 1, 3, 15, 7, 2, 0);
      // R10: config disturbed after acceptance
      access(0, 28'h4000F0F, 16'h0, 0, 2, 0, 5, 3, 1);
      access(1, 28'h0ABCDEF, 16'hC3C3, 1, 1, 2, 1, 0, 1);
      // back-to-back mixed patterns across banks
      for (int i = 0; i < 8; i++) begin
         access(i[0], {i[1:0], 26'(i * 26'h0111111)}, 16'(i * 16'h1357),
                i[1], i, (i * 3) % 16, i * 9, (i * 5) % 16, i[2]);
      end
      @(negedge clk);
      while (q.size() > 0) @(negedge clk);
      repeat (3) @(negedge clk);
      check(req_ready, "R9", "ready after completion", req_ready, 1);
      done_flag = 1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

endmodule